// File: doc/BRIEF.md
# Burst Address Counter Register

This block holds the address that one port of a synchronous memory presents to its array. On every rising clock edge it picks the address for the following cycle from one of four sources: zero, an address driven from outside, its own value plus one, or its own value unchanged. A host can therefore name one starting address and then walk through a burst of consecutive locations with the count-enable pin alone, without driving the address bus again.

The three steering pins are active-low and follow a fixed priority: clearing wins over loading, and loading wins over counting. The counter sees no chip-enable, byte-select or data signal, so it steps even while the port is deselected. A parameter chooses how many low address bits are really decoded. The deep variant uses all 13 bits. The shallow variant decodes 12 of them and keeps the top bit at zero. Counting past the highest decoded address rolls over to zero.

All pins are plain level-sampled controls. No data streams through the block, so it has no valid/ready handshake. The address output changes only on a clock edge.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the synchronous power-on reset `rst_n` is low at a rising edge, `addr` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high, `clr_n` low at a rising edge makes `addr` 0 after that edge, whatever `load_n`, `step_n` and `ext_addr` are.
- R3: With `rst_n` and `clr_n` high, `load_n` low at a rising edge copies the decoded low `USED_W` bits of `ext_addr` into `addr`, whatever `step_n` is.
- R4: With `rst_n`, `clr_n` and `load_n` high, `step_n` low at a rising edge makes `addr` its previous value plus one.
- R5: With all four controls high, `addr` keeps its previous value.
- R6: Stepping from the highest decoded address (all `USED_W` low bits set) gives 0.
- R7: When `USED_W` is less than `ADDR_W`, bits `ADDR_W-1` down to `USED_W` of `addr` are always 0. This holds for loads of addresses that have those bits set, and for wrap-around at 2^`USED_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| ext_addr | input | ADDR_W | Address offered from outside, taken when a load is selected |
| clr_n | input | 1 | Counter clear, active low, highest priority |
| load_n | input | 1 | Address load strobe, active low |
| step_n | input | 1 | Count enable, active low, lowest priority |
| addr | output | ADDR_W | Address in use for the current cycle |

## Verification
Any fault in the held address shows at `addr` in the cycle right after the edge that made it, because the output is the state register itself. The checks therefore compare `addr` after every single edge, not only at the end of a burst. A wrong priority shows when several controls are low together. A wrong increment width shows as a missed rollover at the top address, or as a stray high bit in the shallow variant. Both variants run in lock step against one expected-value model, so a mask fault shows up as a disagreement on that same cycle.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2,
    OP_ZERO = 2'd3
  } bac_op_e;
endpackage

// File: rtl/bac_op_sel.sv
module bac_op_sel
  import bac_pkg::*;
(
  input  logic    rst_n,
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    step_n,
  output bac_op_e op
);
  // fixed priority: power-on reset / clear, then load, then step
  always_comb begin
    if (!rst_n || !clr_n) op = OP_ZERO;
    else if (!load_n)     op = OP_LOAD;
    else if (!step_n)     op = OP_STEP;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int USED_W = 13
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  input  bac_op_e           op,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [USED_W-1:0] ONE = USED_W'(1);

  logic [USED_W-1:0] low_nxt;

  // decoded bits only; rollover is natural modulo 2^USED_W
  always_comb begin
    unique case (op)
      OP_ZERO: low_nxt = '0;
      OP_LOAD: low_nxt = ext[USED_W-1:0];
      OP_STEP: low_nxt = cur[USED_W-1:0] + ONE;
      default: low_nxt = cur[USED_W-1:0];
    endcase
  end

  generate
    if (USED_W == ADDR_W) begin : g_full
      assign nxt = low_nxt;
    end else begin : g_narrow
      localparam int PAD_W = ADDR_W - USED_W;
      assign nxt = {{PAD_W{1'b0}}, low_nxt};
    end
  endgenerate
endmodule

// File: rtl/bac_reg.sv
module bac_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int USED_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] addr
);
  bac_op_e           op;
  logic [ADDR_W-1:0] nxt;

  bac_op_sel u_sel (
    .rst_n (rst_n),
    .clr_n (clr_n),
    .load_n(load_n),
    .step_n(step_n),
    .op    (op)
  );

  bac_next #(.ADDR_W(ADDR_W), .USED_W(USED_W)) u_next (
    .cur(addr),
    .ext(ext_addr),
    .op (op),
    .nxt(nxt)
  );

  bac_reg #(.W(ADDR_W)) u_reg (
    .clk(clk),
    .d  (nxt),
    .q  (addr)
  );
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int ADDR_W = 13,
  parameter int USED_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              clr_n,
  input logic              load_n,
  input logic              step_n,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << USED_W) - 64'd1);

  // R1
  por_zero_chk: assert property (@(posedge clk) !rst_n |=> addr == '0);

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> addr == '0);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> addr == ($past(ext_addr) & MASK));

  // R4 R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |=> addr == (($past(addr) + 1'b1) & MASK));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |=> $stable(addr));

  // R7
  top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr & ~MASK) == '0);
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W), .USED_W(USED_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ext_addr(ext_addr),
  .clr_n   (clr_n),
  .load_n  (load_n),
  .step_n  (step_n),
  .addr    (addr)
);

// File: tb/tb_burst_addr_ctr.sv
module tb_burst_addr_ctr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam logic [AW-1:0] MASK_W = 13'h1FFF;
  localparam logic [AW-1:0] MASK_N = 13'h0FFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_n = 1'b1;
  logic          load_n = 1'b1;
  logic          step_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_w, addr_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] exp_w;
    logic [AW-1:0] exp_n;
    string         req;
  } item_t;

  item_t sb[$];
  logic [AW-1:0] m_w = '0;
  logic [AW-1:0] m_n = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_ctr #(.ADDR_W(AW), .USED_W(13)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .clr_n(clr_n), .load_n(load_n), .step_n(step_n), .addr(addr_w)
  );

  burst_addr_ctr #(.ADDR_W(AW), .USED_W(12)) dut_n (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .clr_n(clr_n), .load_n(load_n), .step_n(step_n), .addr(addr_n)
  );

  function automatic logic [AW-1:0] model(input logic [AW-1:0] prev,
      input logic [AW-1:0] mask, input logic r, input logic c,
      input logic l, input logic s, input logic [AW-1:0] e);
    if (!r || !c)  return '0;
    else if (!l)   return e & mask;
    else if (!s)   return (prev + 1'b1) & mask;
    else           return prev;
  endfunction

  // driver: set inputs at the falling edge, push the value due after the next rising edge
  task automatic drive(input logic r, input logic c, input logic l,
      input logic s, input logic [AW-1:0] e, input string req);
    item_t it;
    @(negedge clk);
    rst_n = r; clr_n = c; load_n = l; step_n = s; ext_addr = e;
    m_w = model(m_w, MASK_W, r, c, l, s, e);
    m_n = model(m_n, MASK_N, r, c, l, s, e);
    it.exp_w = m_w; it.exp_n = m_n; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare one step after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (addr_w !== it.exp_w || addr_n !== it.exp_n) begin
        errors++;
        $display("FAIL %s: wide %h exp %h, narrow %h exp %h",
                 it.req, addr_w, it.exp_w, addr_n, it.exp_n);
      end
    end
  end

  initial begin
    // R1 reset state, other controls active
    drive(0, 0, 0, 0, 13'h1ABC, "R1");
    drive(0, 1, 0, 1, 13'h0555, "R1");
    // R3 load
    drive(1, 1, 0, 1, 13'h0ABC, "R3");
    // R4 burst of steps
    for (int i = 0; i < 3; i++) drive(1, 1, 1, 0, 13'h1111, "R4");
    // R5 hold with a changing bus
    drive(1, 1, 1, 1, 13'h0F0F, "R5");
    drive(1, 1, 1, 1, 13'h1234, "R5");
    // R2 clear beats load and step
    drive(1, 0, 0, 0, 13'h1FFF, "R2");
    // R3 load beats step; R7 top bit masked in narrow variant
    drive(1, 1, 0, 0, 13'h1FFE, "R3_R7");
    // R6 reach top and roll over (narrow at 0x0FFF)
    drive(1, 1, 1, 0, 13'h0000, "R6");
    drive(1, 1, 1, 0, 13'h0000, "R6_R7");
    drive(1, 1, 1, 0, 13'h0000, "R4");
    // R7 load with top bit set, then hold
    drive(1, 1, 0, 1, 13'h1FFF, "R7");
    drive(1, 1, 1, 1, 13'h0000, "R5");
    drive(1, 1, 1, 0, 13'h0000, "R6");
    // mixed pattern sweep
    for (int i = 0; i < 40; i++)
      drive(1, (i % 11) != 5, (i % 7) != 2, (i % 3) == 1,
            AW'(i * 337 + 4000), "R2_R3_R4_R5");
    // R1 reset mid-run
    drive(0, 1, 1, 0, 13'h0777, "R1");
    drive(1, 1, 1, 0, 13'h0000, "R4");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule